// File: doc/BRIEF.md
# Infrared Serial Pulse Codec

This block sits between a UART-style serial engine and an infrared transceiver. On the transmit side it turns every zero bit on the UART's serial output into a short, active-high light pulse. The pulse covers either three or one sixteenths of the bit period. Its timing comes from a 16x baud-rate enable that the surrounding serial engine already produces. One bits and idle time leave the infrared output dark.

On the receive side the infrared input passes through a two-flop synchronizer. The polarity select then chooses whether high or low levels count as pulses. A run-length filter discards any pulse shorter than a programmable minimum width, measured in system clocks. Each pulse that passes drives the recovered serial line low for one bit period, 16 baud enables. A standard UART receiver sampling at mid-bit then sees an ordinary NRZ stream.

An 8-bit control register, written through a single-cycle write strobe and always readable, holds the mode bits. Reset is asserted asynchronously and released synchronously inside the block.

Top module: `ir_sir_codec`

## Requirements
- R1: The control register resets to 0x00 and reads back what was written. The field layout is: bit 7 selects the short pulse, bit 6 selects low receive polarity, bit 5 enables transmit, bit 4 enables receive, and bits 3:0 hold the receive width code.
- R2: With transmit enabled and bit 7 = 0, a zero bit gives an `ir_tx` pulse lasting 3 baud-enable periods. The pulse starts at the enable that opens the bit.
- R3: With transmit enabled and bit 7 = 1, a zero bit gives an `ir_tx` pulse lasting 1 baud-enable period, starting at the bit's first enable.
- R4: A one bit on `uart_txd`, or an idle line, keeps `ir_tx` low.
- R5: With bit 5 = 0, `ir_tx` stays low whatever `uart_txd` does.
- R6: With a legal code c, an active receive level held for at least 2*(c+1) clocks after the synchronizer is accepted. A level held for fewer clocks leaves `uart_rxd` high.
- R7: With bit 6 = 0, high levels on `ir_rx` are pulses. With bit 6 = 1, low levels are pulses and a steady high input is idle.
- R8: With bit 4 = 0, `uart_rxd` stays high and incoming pulses are ignored.
- R9: Width codes 0 and 15 are illegal. While either is programmed, `uart_rxd` stays high.
- R10: An accepted pulse drives `uart_rxd` low from the cycle after acceptance until the 16th baud enable that follows. That is a low time of 121 to 128 clocks when enables come every 8 clocks.
- R11: When `ir_tx` is looped back to `ir_rx` (inverted for low polarity), bytes framed on `uart_txd` are recovered intact on `uart_rxd` with either pulse width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Current control register contents |
| baud16_en | input | 1 | One-cycle enable at 16 times the baud rate |
| uart_txd | input | 1 | Serial data from the UART transmitter, idle high |
| ir_tx | output | 1 | Pulse output to the infrared emitter, active high |
| ir_rx | input | 1 | Raw input from the infrared detector |
| uart_rxd | output | 1 | Recovered serial data to the UART receiver, idle high |

## Verification
The bench probes the glitch filter one clock either side of its threshold, at the smallest and the largest legal codes. An off-by-one comparator would accept the short glitch or reject the exact-length pulse. It runs strings of consecutive zero bits. A phase counter that failed to wrap would emit one pulse per run, and a recovered line that rose between bits would corrupt the byte. It checks the illegal codes, the disabled paths and the inverted polarity, where a missing gate would let a steady idle level or a valid pulse through. It also measures the recovered low time, because a hold counter that is one enable off would shift every UART sample point.

// File: rtl/ir_sir_pkg.sv
package ir_sir_pkg;

  // Baud enables per bit and the phase counter width that covers them
  localparam int OVS    = 16;
  localparam int PH_W   = $clog2(OVS);
  // Receive width code and the run counter that spans 2*(code+1)
  localparam int CODE_W = 4;
  localparam int CNT_W  = CODE_W + 2;
  // Transmit pulse lengths in baud-enable periods
  localparam int LONG_LEN  = 3;
  localparam int SHORT_LEN = 1;
  localparam int CFG_W     = 4 + CODE_W;

  typedef struct packed {
    logic              pw_short;   // bit 7
    logic              rx_low_act; // bit 6
    logic              tx_on;      // bit 5
    logic              rx_on;      // bit 4
    logic [CODE_W-1:0] rx_code;    // bits 3:0
  } ir_cfg_t;

endpackage

// File: rtl/ir_sir_rst_sync.sv
module ir_sir_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] shf_q;
  logic [STAGES-1:0] shf_d;

  always_comb begin
    shf_d = {shf_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shf_q <= '0;
    else         shf_q <= shf_d;
  end

  assign srst_n = shf_q[STAGES-1];

endmodule

// File: rtl/ir_sir_bit_sync.sv
module ir_sir_bit_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/ir_sir_cfg_reg.sv
module ir_sir_cfg_reg
  import ir_sir_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output ir_cfg_t          cfg
);

  ir_cfg_t cfg_q;
  ir_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we) cfg_d = ir_cfg_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/ir_sir_tx_mod.sv
module ir_sir_tx_mod #(
  parameter int PH_W      = ir_sir_pkg::PH_W,
  parameter int LONG_LEN  = ir_sir_pkg::LONG_LEN,
  parameter int SHORT_LEN = ir_sir_pkg::SHORT_LEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_on,
  input  logic pw_short,
  input  logic baud_en,
  input  logic txd,
  output logic ir_out
);

  logic [PH_W-1:0] phase_q, phase_d;
  logic            prev_q,  prev_d;
  logic            pulse_q, pulse_d;
  logic [PH_W-1:0] pulse_len;
  logic            edge_seen;
  logic [PH_W-1:0] phase_nx;

  assign pulse_len = pw_short ? PH_W'(SHORT_LEN) : PH_W'(LONG_LEN);
  assign edge_seen = (txd != prev_q);
  // A level change opens a new bit at phase 0; a run of equal bits
  // wraps the counter, so each following bit restarts at phase 0 too.
  assign phase_nx  = edge_seen ? '0 : phase_q + PH_W'(1);

  always_comb begin
    phase_d = phase_q;
    prev_d  = prev_q;
    pulse_d = pulse_q;
    if (baud_en) begin
      phase_d = phase_nx;
      prev_d  = txd;
      pulse_d = !txd && (phase_nx < pulse_len);
    end
    if (!tx_on) pulse_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      prev_q  <= 1'b1;
      pulse_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      prev_q  <= prev_d;
      pulse_q <= pulse_d;
    end
  end

  assign ir_out = pulse_q;

endmodule

// File: rtl/ir_sir_rx_demod.sv
module ir_sir_rx_demod #(
  parameter int CODE_W   = ir_sir_pkg::CODE_W,
  parameter int PH_W     = ir_sir_pkg::PH_W,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_on,
  input  logic              low_act,
  input  logic [CODE_W-1:0] code,
  input  logic              baud_en,
  input  logic              ir_in,
  output logic              rxd
);

  localparam int CNT_W = CODE_W + 2;
  localparam logic [PH_W-1:0] LAST_PH = '1;

  logic             ir_s;
  logic             active;
  logic             code_ok;
  logic             path_on;
  logic [CNT_W-1:0] thr;
  logic             hit;

  logic [CNT_W-1:0] run_q,  run_d;
  logic [PH_W-1:0]  hold_q, hold_d;
  logic             low_q,  low_d;

  ir_sir_bit_sync #(
    .STAGES  (SYNC_STG),
    .RST_VAL (1'b0)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (ir_in),
    .dout  (ir_s)
  );

  assign active  = ir_s ^ low_act;
  assign code_ok = (code != '0) && (code != '1);
  assign path_on = rx_on && code_ok;
  // minimum run = 2*(code+1) clocks
  assign thr     = CNT_W'({code, 1'b0}) + CNT_W'(2);
  assign hit     = path_on && active && (run_q == thr - CNT_W'(1));

  always_comb begin
    run_d  = run_q;
    hold_d = hold_q;
    low_d  = low_q;
    if (!path_on) begin
      run_d  = '0;
      hold_d = '0;
      low_d  = 1'b0;
    end else begin
      if (!active)          run_d = '0;
      else if (run_q < thr) run_d = run_q + CNT_W'(1);

      if (hit) begin
        low_d  = 1'b1;
        hold_d = '0;
      end else if (low_q && baud_en) begin
        if (hold_q == LAST_PH) begin
          low_d  = 1'b0;
          hold_d = '0;
        end else begin
          hold_d = hold_q + PH_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      hold_q <= '0;
      low_q  <= 1'b0;
    end else begin
      run_q  <= run_d;
      hold_q <= hold_d;
      low_q  <= low_d;
    end
  end

  assign rxd = !low_q;

endmodule

// File: rtl/ir_sir_codec.sv
module ir_sir_codec
  import ir_sir_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             baud16_en,
  input  logic             uart_txd,
  output logic             ir_tx,
  input  logic             ir_rx,
  output logic             uart_rxd
);

  logic    rst_sync_n;
  ir_cfg_t cfg;

  ir_sir_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  ir_sir_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  ir_sir_tx_mod #(
    .PH_W      (PH_W),
    .LONG_LEN  (LONG_LEN),
    .SHORT_LEN (SHORT_LEN)
  ) u_tx (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tx_on    (cfg.tx_on),
    .pw_short (cfg.pw_short),
    .baud_en  (baud16_en),
    .txd      (uart_txd),
    .ir_out   (ir_tx)
  );

  ir_sir_rx_demod #(
    .CODE_W   (CODE_W),
    .PH_W     (PH_W),
    .SYNC_STG (2)
  ) u_rx (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rx_on   (cfg.rx_on),
    .low_act (cfg.rx_low_act),
    .code    (cfg.rx_code),
    .baud_en (baud16_en),
    .ir_in   (ir_rx),
    .rxd     (uart_rxd)
  );

  assign cfg_rdata = cfg;

endmodule

// File: rtl/ir_sir_codec_chk.sv
module ir_sir_codec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cfg,
  input logic       baud16_en,
  input logic       uart_txd,
  input logic       ir_tx,
  input logic       uart_rxd
);

  AST_TX_OFF_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg[5] |=> !ir_tx); // R5

  AST_TX_ONE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (baud16_en && uart_txd) |=> !ir_tx); // R4

  AST_TX_SHORT_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[7] && ir_tx && baud16_en) |=> !ir_tx); // R3

  AST_RX_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg[4] |=> uart_rxd); // R8

  AST_RX_BADCODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[3:0] == 4'h0 || cfg[3:0] == 4'hF) |=> uart_rxd); // R9

endmodule

bind ir_sir_codec ir_sir_codec_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cfg       (cfg_rdata),
  .baud16_en (baud16_en),
  .uart_txd  (uart_txd),
  .ir_tx     (ir_tx),
  .uart_rxd  (uart_rxd)
);

// File: tb/ir_sir_codec_bench.sv
module ir_sir_codec_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 8;
  localparam int BIT_CLKS   = 16 * TICK_DIV;

  logic       clk;
  logic       rst_n;
  logic       cfg_we;
  logic [7:0] cfg_wdata;
  logic [7:0] cfg_rdata;
  logic       baud16_en;
  logic       uart_txd;
  logic       ir_tx;
  logic       ir_rx;
  logic       uart_rxd;

  logic       loop_on;
  logic       loop_inv;
  logic       man_rx;
  logic [3:0] div_q;

  int checks;
  int fails;

  ir_sir_codec u_ir_sir_codec (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .baud16_en (baud16_en),
    .uart_txd  (uart_txd),
    .ir_tx     (ir_tx),
    .ir_rx     (ir_rx),
    .uart_rxd  (uart_rxd)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (div_q == 4'(TICK_DIV - 1)) div_q <= '0;
    else                           div_q <= div_q + 4'd1;
  end
  assign baud16_en = (div_q == '0);

  assign ir_rx = loop_on ? (loop_inv ? ~ir_tx : ir_tx) : man_rx;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] v);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic align_tick();
    do @(negedge clk); while (!baud16_en);
  endtask

  // Drives one bit starting at a negedge whose following posedge is a tick.
  // Returns the number of clocks ir_tx was high and its first sample.
  task automatic drive_bit(input logic b, output int ones, output logic first);
    uart_txd = b;
    ones = 0;
    first = 1'b0;
    for (int i = 0; i < BIT_CLKS; i++) begin
      @(negedge clk);
      if (i == 0) first = ir_tx;
      if (ir_tx) ones++;
    end
  endtask

  // Sends start, 8 data bits LSB first, stop, one idle bit.
  task automatic send_frame(input logic [7:0] data, input int exp_len,
                            input string tag, output int bad);
    logic [9:0] frame;
    int ones;
    logic first;
    frame = {1'b1, data, 1'b0};
    bad = 0;
    align_tick();
    for (int k = 0; k < 11; k++) begin
      logic b;
      int exp_ones;
      b = (k < 10) ? frame[k] : 1'b1;
      drive_bit(b, ones, first);
      exp_ones = b ? 0 : exp_len * TICK_DIV;
      if (ones != exp_ones || first != (exp_ones != 0)) begin
        if (bad == 0)
          $display("FAIL %s bit %0d pulse clocks actual=%0d expected=%0d",
                   tag, k, ones, exp_ones);
        bad++;
      end
    end
  endtask

  task automatic recv_byte(output logic [7:0] data, output bit ok);
    int t;
    ok = 1'b0;
    data = '0;
    t = 0;
    while (uart_rxd && t < 3000) begin
      @(negedge clk);
      t++;
    end
    if (uart_rxd) return;
    wait_clks(BIT_CLKS/2);
    if (uart_rxd) return;
    for (int i = 0; i < 8; i++) begin
      wait_clks(BIT_CLKS);
      data[i] = uart_rxd;
    end
    wait_clks(BIT_CLKS);
    ok = uart_rxd;
  endtask

  task automatic loop_byte(input logic [7:0] data, input int exp_len, input string tag);
    int bad;
    logic [7:0] got;
    bit ok;
    fork
      send_frame(data, exp_len, tag, bad);
      recv_byte(got, ok);
    join
    checks++;
    if (bad != 0) fails++;
    check(ok && got == data, {"R11 loopback ", tag}, int'(got), int'(data));
  endtask

  // Applies an active level for n clocks, then idles, on the manual input.
  task automatic pulse(input logic act_lvl, input int n);
    man_rx = act_lvl;
    wait_clks(n);
    man_rx = ~act_lvl;
  endtask

  task automatic count_low(input int n, output int lows);
    lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!uart_rxd) lows++;
    end
  endtask

  task automatic t_reset_and_cfg();
    check(cfg_rdata == 8'h00, "R1 reset value", cfg_rdata, 0);
    check(ir_tx == 1'b0, "R4 ir_tx idle after reset", ir_tx, 0);
    check(uart_rxd == 1'b1, "R8 uart_rxd idle after reset", uart_rxd, 1);
    cfg_write(8'hA5);
    check(cfg_rdata == 8'hA5, "R1 readback", cfg_rdata, 8'hA5);
    cfg_write(8'h5A);
    check(cfg_rdata == 8'h5A, "R1 readback", cfg_rdata, 8'h5A);
    cfg_write(8'h00);
  endtask

  task automatic t_tx_idle_and_off();
    int ones;
    int bad;
    cfg_write(8'h20);
    uart_txd = 1'b1;
    ones = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (ir_tx) ones++;
    end
    check(ones == 0, "R4 idle line dark", ones, 0);
    cfg_write(8'h00);
    send_frame(8'h00, 0, "R5 tx disabled", bad);
    check(bad == 0, "R5 tx disabled frame dark", bad, 0);
  endtask

  task automatic t_glitch(input logic [3:0] code);
    int thr;
    int lows;
    int t;
    thr = 2 * (int'(code) + 1);
    loop_on = 1'b0;
    man_rx  = 1'b0;
    cfg_write({4'b0001, code});
    wait_clks(10);
    pulse(1'b1, thr - 1);
    count_low(80, lows);
    check(lows == 0, "R6 glitch one clock short rejected", lows, 0);
    pulse(1'b1, thr);
    t = 0;
    while (uart_rxd && t < 40) begin
      @(negedge clk);
      t++;
    end
    check(!uart_rxd, "R6 pulse at threshold accepted", uart_rxd, 0);
    lows = 0;
    while (!uart_rxd && lows < 400) begin
      @(negedge clk);
      lows++;
    end
    check(lows >= BIT_CLKS - TICK_DIV + 1 && lows <= BIT_CLKS,
          "R10 recovered low time", lows, BIT_CLKS);
    wait_clks(20);
  endtask

  task automatic t_rx_gating();
    int lows;
    loop_on = 1'b0;
    man_rx  = 1'b0;
    cfg_write(8'h03);
    wait_clks(5);
    pulse(1'b1, 40);
    count_low(180, lows);
    check(lows == 0, "R8 rx disabled ignores pulse", lows, 0);
    cfg_write(8'h10);
    wait_clks(5);
    pulse(1'b1, 40);
    count_low(180, lows);
    check(lows == 0, "R9 code 0 stays idle", lows, 0);
    cfg_write(8'h1F);
    wait_clks(5);
    pulse(1'b1, 40);
    count_low(180, lows);
    check(lows == 0, "R9 code 15 stays idle", lows, 0);
  endtask

  task automatic t_polarity();
    int lows;
    int t;
    loop_on = 1'b0;
    man_rx  = 1'b1;
    wait_clks(5);
    cfg_write(8'h53);
    count_low(200, lows);
    check(lows == 0, "R7 high idle not taken as pulse", lows, 0);
    pulse(1'b0, 8);
    t = 0;
    while (uart_rxd && t < 40) begin
      @(negedge clk);
      t++;
    end
    check(!uart_rxd, "R7 low pulse accepted", uart_rxd, 0);
    wait_clks(200);
  endtask

  task automatic t_loopback(input logic pw_short, input logic inv);
    int len;
    len = pw_short ? 1 : 3;
    uart_txd = 1'b1;
    cfg_write(8'h00);
    loop_inv = inv;
    loop_on  = 1'b1;
    cfg_write({pw_short, inv, 2'b11, 4'd3});
    wait_clks(300);
    loop_byte(8'h55, len, pw_short ? "R3 short 55" : "R2 long 55");
    loop_byte(8'h00, len, pw_short ? "R3 short 00" : "R2 long 00");
    loop_byte(8'hA3, len, pw_short ? "R3 short A3" : "R2 long A3");
    if (inv) loop_byte(8'h0F, len, "R7 inverted 0F");
    loop_on = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    checks    = 0;
    fails     = 0;
    div_q     = '0;
    rst_n     = 1'b0;
    cfg_we    = 1'b0;
    cfg_wdata = '0;
    uart_txd  = 1'b1;
    loop_on   = 1'b0;
    loop_inv  = 1'b0;
    man_rx    = 1'b0;
    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(5);

    t_reset_and_cfg();
    t_tx_idle_and_off();
    t_glitch(4'd1);
    t_glitch(4'd14);
    t_rx_gating();
    t_polarity();
    t_loopback(1'b0, 1'b0);
    t_loopback(1'b1, 1'b0);
    t_loopback(1'b1, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule